// File: doc/BRIEF.md
# Programmable Counter/Timer Channel

This block is a single channel of a multi-channel counter/timer peripheral. Software sets it up through one byte-wide write port. It first writes a control word that selects the mode, the prescale ratio, the trigger edge and the interrupt enable. It then writes a time-constant word that becomes the reload value of an 8-bit down-counter. In timer mode, the system clock passes through a prescaler of 16 or 256 and then decrements the counter. In counter mode, the counter decrements once for each selected edge of an external trigger input. That input is synchronised by two flops before edge detection.

When the counter steps from 1, it reloads the time constant on its own and drives a one-cycle timeout pulse. If interrupts are enabled, it also sets an interrupt request, which stays high until it is acknowledged. Vector delivery, priority chaining and bus decode belong to the surrounding peripheral.

Top module: `cnt_timer_chan`

## Requirements
- R1: While no time constant is awaited, a written byte with bit 0 set is a control word. If its bit 2 is set, the next write, whatever its value, is taken as the time constant. From that control word until the time constant arrives, the channel does not count and produces no timeout pulse.
- R2: Bit 6 of the control word at 0 selects timer mode. In timer mode, bit 4 selects the prescale ratio: 0 gives 16 and 1 gives 256. With time constant N, the first timeout pulse is seen N×ratio cycles after the cycle in which the time constant was written.
- R3: A time constant of 0 acts as 256.
- R4: When the count steps from 1, the counter reloads the time constant by itself. Successive timeout pulses are therefore spaced by the same period.
- R5: Bit 6 at 1 selects counter mode. The counter decrements once per trigger edge of the kind set by bit 3 (1 rising, 0 falling), and edges of the other kind are ignored. A timeout pulse caused by a trigger edge rises on the third clock edge after the trigger input changes.
- R6: `zeroOut` is high for exactly one clock cycle per timeout.
- R7: A control word with bit 1 set and bit 2 clear stops counting. The channel stays stopped until a new time constant is written.
- R8: A timeout sets `irqOut` only while bit 7 (interrupt enable) of the control word is 1. Once set, `irqOut` stays high until `irqAck` is sampled high.
- R9: A write whose bit 0 is clear, made while no time constant is awaited, is ignored and leaves the mode and count untouched.
- R10: After reset both outputs are low, and the channel does not count until it has been programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register port |
| wrData | input | 8 | Control word or time-constant word |
| trigIn | input | 1 | External clock/trigger input (asynchronous) |
| irqAck | input | 1 | Interrupt acknowledge, clears the request |
| zeroOut | output | 1 | One-cycle timeout pulse |
| irqOut | output | 1 | Held interrupt request |

## Verification
In timer mode, a timeout is due exactly N×ratio cycles after the cycle that wrote the time constant. The bench counts falling clock edges from the end of that write to the first high sample of `zeroOut`, then counts again to the next pulse to confirm the reload period. In counter mode, the two synchroniser flops plus the output register place the pulse on the third clock edge after the trigger change. The bench therefore moves the trigger on a falling edge and expects the pulse on the third falling edge after that. The interrupt request appears on the same edge as the pulse and drops one edge after an acknowledge. Each of these is sampled half a cycle after the edge that produces it.

// File: rtl/cnt_timer_pkg.sv
package cnt_timer_pkg;
  // control-word field positions
  localparam int BIT_CTL     = 0;
  localparam int BIT_SRST    = 1;
  localparam int BIT_TCF     = 2;
  localparam int BIT_RISE    = 3;
  localparam int BIT_DIV     = 4;
  localparam int BIT_CNTMODE = 6;
  localparam int BIT_IE      = 7;

  typedef struct packed {
    logic load;         // load time constant, clear prescaler
    logic run;          // counting enabled
    logic counterMode;  // 1: trigger edges, 0: prescaled clock
    logic risingEdge;   // trigger edge select
    logic div256;       // prescale select
  } chanStrobe_t;
endpackage

// File: rtl/cnt_timer_ctrl.sv
module cnt_timer_ctrl
  import cnt_timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              zeroEvt,
  input  logic              irqAck,
  output chanStrobe_t       strobe,
  output logic              awaitTc,
  output logic              intEn,
  output logic              irqOut
);
  logic running, cntMode, riseSel, divSel;
  logic isCtl;
  logic unusedBits;

  assign isCtl      = wrEn && !awaitTc && wrData[BIT_CTL];
  assign unusedBits = ^wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awaitTc <= 1'b0;
      running <= 1'b0;
      cntMode <= 1'b0;
      riseSel <= 1'b0;
      divSel  <= 1'b0;
      intEn   <= 1'b0;
    end else if (wrEn && awaitTc) begin
      awaitTc <= 1'b0;
      running <= 1'b1;
    end else if (isCtl) begin
      cntMode <= wrData[BIT_CNTMODE];
      riseSel <= wrData[BIT_RISE];
      divSel  <= wrData[BIT_DIV];
      intEn   <= wrData[BIT_IE];
      if (wrData[BIT_TCF]) begin
        awaitTc <= 1'b1;
        running <= 1'b0;
      end else if (wrData[BIT_SRST]) begin
        running <= 1'b0;
      end
    end
  end

  // request set has priority over acknowledge
  always_ff @(posedge clk) begin
    if (!rstN)                  irqOut <= 1'b0;
    else if (zeroEvt && intEn)  irqOut <= 1'b1;
    else if (irqAck)            irqOut <= 1'b0;
  end

  always_comb begin
    strobe.load        = wrEn && awaitTc;
    strobe.run         = running;
    strobe.counterMode = cntMode;
    strobe.risingEdge  = riseSel;
    strobe.div256      = divSel;
  end
endmodule

// File: rtl/cnt_timer_dp.sv
module cnt_timer_dp
  import cnt_timer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PRE_W   = 8,
  parameter int LO_LOG2 = 4,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobe_t      strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic             trigIn,
  output logic             zeroEvt,
  output logic             zeroOut,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] tcReg
);
  localparam int HIST_W = SYNC_N + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [HIST_W-1:0] trigHist;
  logic [PRE_W-1:0]  preCnt;
  logic trigNow, trigPrev, edgeHit, preTick, tick;

  assign trigNow  = trigHist[SYNC_N-1];
  assign trigPrev = trigHist[SYNC_N];
  assign edgeHit  = strobe.risingEdge ? (trigNow && !trigPrev)
                                      : (!trigNow && trigPrev);
  assign preTick  = strobe.div256 ? (&preCnt) : (&preCnt[LO_LOG2-1:0]);
  assign tick     = strobe.run && (strobe.counterMode ? edgeHit : preTick);
  assign zeroEvt  = tick && (cnt == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) trigHist <= '0;
    else       trigHist <= {trigHist[HIST_W-2:0], trigIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.load)
      preCnt <= '0;
    else if (strobe.run && !strobe.counterMode)
      preCnt <= preTick ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      tcReg <= '0;
    end else if (strobe.load) begin
      cnt   <= wrData;
      tcReg <= wrData;
    end else if (tick) begin
      cnt <= (cnt == CNT_ONE) ? tcReg : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) zeroOut <= 1'b0;
    else       zeroOut <= zeroEvt;
  end
endmodule

// File: rtl/cnt_timer_chan.sv
module cnt_timer_chan
  import cnt_timer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int LO_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic             trigIn,
  input  logic             irqAck,
  output logic             zeroOut,
  output logic             irqOut
);
  chanStrobe_t      strobe;
  logic             zeroEvt, awaitTc, intEn;
  logic [CNT_W-1:0] cnt, tcReg;

  cnt_timer_ctrl #(.DATA_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .zeroEvt(zeroEvt), .irqAck(irqAck), .strobe(strobe),
    .awaitTc(awaitTc), .intEn(intEn), .irqOut(irqOut)
  );

  cnt_timer_dp #(.CNT_W(CNT_W), .PRE_W(CNT_W), .LO_LOG2(LO_LOG2), .SYNC_N(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .trigIn(trigIn), .zeroEvt(zeroEvt), .zeroOut(zeroOut),
    .cnt(cnt), .tcReg(tcReg)
  );
endmodule

// File: rtl/cnt_timer_chan_chk.sv
module cnt_timer_chan_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             zeroOut,
  input logic             irqOut,
  input logic             irqAck,
  input logic             intEn,
  input logic             running,
  input logic             awaitTc,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tcReg
);
  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    zeroOut |=> !zeroOut);

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqAck) |=> irqOut);

  assert_irq_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(intEn) && zeroOut));

  assert_wait_tc_R1: assert property (@(posedge clk) disable iff (!rstN)
    (awaitTc && !wrEn) |=> ($stable(cnt) && !zeroOut));

  assert_stopped_R7: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> !zeroOut);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    zeroOut |-> (cnt == tcReg));
endmodule

bind cnt_timer_chan cnt_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .zeroOut(zeroOut), .irqOut(irqOut),
  .irqAck(irqAck), .intEn(intEn), .running(strobe.run), .awaitTc(awaitTc),
  .cnt(cnt), .tcReg(tcReg)
);

// File: tb/cnt_timer_chan_bench.sv
module cnt_timer_chan_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic trigIn = 1'b0;
  logic irqAck = 1'b0;
  logic zeroOut, irqOut;

  int total = 0;
  int bad = 0;
  int zeroCount = 0;
  int widthErr = 0;
  bit prevZ = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cnt_timer_chan u_cnt_timer_chan (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .trigIn(trigIn), .irqAck(irqAck), .zeroOut(zeroOut), .irqOut(irqOut)
  );

  // pulse monitor on falling edges
  always @(negedge clk) begin
    if (zeroOut) zeroCount++;
    if (zeroOut && prevZ) widthErr++;
    prevZ = zeroOut;
  end

  // {ctl, tc, expected cycles}
  localparam logic [31:0] VEC [5] = '{
    32'h8501_0010,  // R2 div16 N=1
    32'h8505_0050,  // R2 div16 N=5
    32'h9502_0200,  // R2 div256 N=2
    32'h8500_1000,  // R3 N=0 -> 256*16
    32'h9501_0100   // R2 div256 N=1
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic waitZero(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!zeroOut && n < 20000);
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state, no counting before programming
    chk(zeroOut == 1'b0, "R10 zeroOut", zeroOut, 0);
    chk(irqOut == 1'b0, "R10 irqOut", irqOut, 0);
    for (int i = 0; i < 5; i++) begin
      trigIn = 1'b1; idle(5);
      trigIn = 1'b0; idle(5);
    end
    idle(250);
    chk(zeroCount == 0, "R10 idle pulses", zeroCount, 0);

    // vector table: first timeout latency and reload period
    for (int v = 0; v < 5; v++) begin
      wr(VEC[v][31:24]);
      wr(VEC[v][23:16]);
      waitZero(n);
      chk(n == int'(VEC[v][15:0]), "R2 first timeout", n, int'(VEC[v][15:0]));
      waitZero(n);
      chk(n == int'(VEC[v][15:0]), "R4 reload period", n, int'(VEC[v][15:0]));
    end

    // R1 no counting while time constant awaited
    wr(8'h85);
    base = zeroCount;
    idle(100);
    chk(zeroCount == base, "R1 awaiting tc", zeroCount - base, 0);
    wr(8'd1);
    waitZero(n);
    chk(n == 16, "R1 after tc", n, 16);

    // R8 held request, acknowledge
    chk(irqOut == 1'b1, "R8 irq set", irqOut, 1);
    idle(40);
    chk(irqOut == 1'b1, "R8 irq held", irqOut, 1);
    waitZero(n);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    chk(irqOut == 1'b0, "R8 irq ack", irqOut, 1'b0);
    waitZero(n);
    chk(irqOut == 1'b1, "R8 irq re-set", irqOut, 1);

    // R8 no request when disabled
    wr(8'h05);
    wr(8'd1);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    base = zeroCount;
    idle(100);
    chk(zeroCount > base, "R8 pulses without ie", zeroCount - base, 6);
    chk(irqOut == 1'b0, "R8 irq disabled", irqOut, 0);

    // R7 software reset stops counting
    wr(8'h85);
    wr(8'd1);
    waitZero(n);
    wr(8'h03);
    base = zeroCount;
    idle(100);
    chk(zeroCount == base, "R7 stopped", zeroCount - base, 0);
    wr(8'h85);
    wr(8'd1);
    waitZero(n);
    chk(n == 16, "R7 restart", n, 16);

    // R9 write with bit0 clear ignored
    wr(8'h85);
    wr(8'd2);
    waitZero(n);
    wr(8'hFE);
    waitZero(n);
    chk(n == 31, "R9 phase kept", n, 31);
    waitZero(n);
    chk(n == 32, "R9 period kept", n, 32);

    // R5 counter mode, rising edge, tc=3
    wr(8'hCD);
    wr(8'd3);
    base = zeroCount;
    for (int p = 0; p < 2; p++) begin
      trigIn = 1'b1; idle(4);
      trigIn = 1'b0; idle(4);
    end
    chk(zeroCount == base, "R5 two rising", zeroCount - base, 0);
    trigIn = 1'b1;
    waitZero(n);
    chk(n == 3, "R5 rising latency", n, 3);
    trigIn = 1'b0; idle(6);
    chk(zeroCount == base + 1, "R5 falling ignored", zeroCount - base, 1);

    // R5 counter mode, falling edge, tc=2
    wr(8'hC5);
    wr(8'd2);
    base = zeroCount;
    trigIn = 1'b1; idle(6);
    chk(zeroCount == base, "R5 rising ignored", zeroCount - base, 0);
    trigIn = 1'b0; idle(6);
    trigIn = 1'b1; idle(6);
    chk(zeroCount == base, "R5 one falling", zeroCount - base, 0);
    trigIn = 1'b0;
    waitZero(n);
    chk(n == 3, "R5 falling latency", n, 3);
    idle(4);

    // R6 one-cycle pulse width across the run
    chk(widthErr == 0, "R6 pulse width", widthErr, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule